// File: doc/BRIEF.md
# Residue Magnitude Comparator

This block compares two unsigned integers A and B that are held in residue form over the moduli 2^N-1, 2^N and 2^N+1. Each operand arrives as three residues. The mod 2^N-1 residue and the mod 2^N residue are N bits each. The mod 2^N+1 residue is N+1 bits, and it reaches its top value 2^N only when bit N is set. The block answers two questions: whether A equals B, and whether A is greater than B. It never rebuilds either operand in binary.

For each operand, the block builds a three-digit weighted kernel (H, M, L). The value satisfies V = (2^N+1)·2^N·H + (2^N+1)·M + L. Here L is the mod 2^N+1 residue itself, M is a mod 2^N difference, and H is a mod 2^N-1 sum of rotated and inverted residues. The two kernels are then compared digit by digit, starting with H, then M, then all N+1 bits of L. The three digit comparisons run side by side, and two cascaded 2:1 selections pick the deciding one.

The parameter N must be at least 2. Operands are assumed to be valid residues. An optional output register adds one cycle of latency, with a valid bit that travels alongside the data. A second parameter chooses how the decremented high digit is produced.

Top module: `rnscmp_top`

## Requirements
- R1: While a beat is valid, a_eq_b is 1 exactly when the integer value of A equals that of B.
- R2: While a beat is valid, a_gt_b is 1 exactly when A is greater than B. It is 0 when A is less than or equal to B.
- R3: a_eq_b and a_gt_b are never 1 at the same time.
- R4: The result is correct when the mod 2^N+1 residue (bit N of a_mhi or b_mhi) equals 2^N, on either operand or on both.
- R5: The result is correct when an operand's mod 2^N residue is below its mod 2^N+1 residue, which is the case where the high kernel digit takes the value decremented by one modulo 2^N-1.
- R6: With REG_OUT=1, out_valid equals the in_valid value sampled at the previous rising edge, and the flags reflect the operands sampled at that edge and hold until the next edge. With REG_OUT=0, out_valid and the flags follow the inputs within the same cycle.
- R7: While out_valid is 0, a_eq_b and a_gt_b are both 0.
- R8: While rst_n is low, a registered build drives out_valid, a_eq_b and a_gt_b to 0.
- R9: PARALLEL_DEC=1 forms the decremented high digit with its own four-operand modular sum. PARALLEL_DEC=0 forms it by decrementing the plain sum. Both settings give the same results for every valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on the inputs are valid this cycle |
| a_mlo | input | N | Residue of A modulo 2^N-1 |
| a_mmid | input | N | Residue of A modulo 2^N |
| a_mhi | input | N+1 | Residue of A modulo 2^N+1 |
| b_mlo | input | N | Residue of B modulo 2^N-1 |
| b_mmid | input | N | Residue of B modulo 2^N |
| b_mhi | input | N+1 | Residue of B modulo 2^N+1 |
| out_valid | output | 1 | Result flags are valid |
| a_eq_b | output | 1 | A equals B |
| a_gt_b | output | 1 | A is greater than B |

## Verification
The bench builds three instances.

- **N=2, registered, parallel decrement:** the bench sweeps every ordered pair in the full 60-value range. This reaches every combination of top-residue, borrow and digit-tie cases, together with the one-cycle timing.
- **N=3, combinational, cascaded decrement:** the bench walks all 504 values of A against a strided set of B values plus B equal to A. This exercises the other decrement variant and the same-cycle path.
- **N=5, registered, cascaded decrement:** the bench uses random pairs over the 32736-value range, plus equal pairs. This shows that the rotations and the modular folding scale beyond the tiny widths.

// File: rtl/rnscmp_pkg.sv
package rnscmp_pkg;

    // Per-digit comparison outcome.
    typedef struct packed {
        logic e;    // digits equal
        logic c;    // first digit greater
    } digit_cmp_t;

    // Result word carried through the optional output stage.
    typedef struct packed {
        logic vld;
        logic eq;
        logic gt;
    } rnscmp_res_t;

endpackage

// File: rtl/rnscmp_m1_add.sv
// Three-operand adder modulo 2^N-1 with canonical output in [0, 2^N-2].
// Also produces (sum - 1) mod 2^N-1, selected by PARALLEL_DEC:
//   1: separate four-operand sum with the constant 2^N-2 (short path)
//   0: decrement applied to the reduced sum (less logic, longer path)
module rnscmp_m1_add #(
    parameter int N            = 4,
    parameter bit PARALLEL_DEC = 1'b1
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic [N-1:0] op_c,
    output logic [N-1:0] sum,
    output logic [N-1:0] sum_dec
);
    localparam int          SW    = N + 2;
    localparam logic [N-1:0] ALL1  = {N{1'b1}};
    localparam logic [N-1:0] DEC_K = {{(N-1){1'b1}}, 1'b0};

    // Reduce a value below 2^(N+2) modulo 2^N-1 by two end-around folds.
    function automatic logic [N-1:0] fold_m1(input logic [SW-1:0] s);
        logic [N:0]   t;
        logic [N-1:0] u;
        t = {1'b0, s[N-1:0]} + {{(N-1){1'b0}}, s[SW-1:N]};
        u = t[N-1:0] + {{(N-1){1'b0}}, t[N]};
        return (u == ALL1) ? '0 : u;
    endfunction

    logic [SW-1:0] raw_sum;

    always_comb begin
        raw_sum = {2'b00, op_a} + {2'b00, op_b} + {2'b00, op_c};
        sum     = fold_m1(raw_sum);
    end

    generate
        if (PARALLEL_DEC) begin : g_par_dec
            logic [SW-1:0] raw_dec;
            always_comb begin
                raw_dec = raw_sum + {2'b00, DEC_K};
                sum_dec = fold_m1(raw_dec);
            end
        end else begin : g_cas_dec
            always_comb begin
                sum_dec = (sum == '0) ? DEC_K : (sum - 1'b1);
            end
        end
    endgenerate

endmodule

// File: rtl/rnscmp_kernel.sv
// Converts one residue triple into the two upper mixed-radix digits.
// The lowest digit is the mod 2^N+1 residue itself.
module rnscmp_kernel #(
    parameter int N            = 4,
    parameter bit PARALLEL_DEC = 1'b1
) (
    input  logic [N-1:0] res_m1,   // mod 2^N-1
    input  logic [N-1:0] res_p2,   // mod 2^N
    input  logic [N:0]   res_p1,   // mod 2^N+1
    output logic [N-1:0] dig_hi,
    output logic [N-1:0] dig_mid
);
    localparam logic [N-1:0] HALF_M1 = {1'b0, {(N-1){1'b1}}};

    logic         top_flag;
    logic [N-1:0] low_bits;
    logic [N:0]   sub_w;
    logic         borrow;
    logic [N-1:0] term_1;
    logic [N-1:0] term_2;
    logic [N-1:0] term_3;
    logic [N-1:0] z_sum;
    logic [N-1:0] z_dec;

    always_comb begin
        top_flag = res_p1[N];
        low_bits = res_p1[N-1:0];
        sub_w    = {1'b0, res_p2} - {1'b0, low_bits};
        borrow   = sub_w[N];
        // times 2^(N-1) modulo 2^N-1 is a right rotate by one
        term_1   = top_flag ? HALF_M1 : {low_bits[0], low_bits[N-1:1]};
        // negation modulo 2^N-1 is bitwise inversion
        term_2   = ~res_p2;
        term_3   = {res_m1[0], res_m1[N-1:1]};
    end

    rnscmp_m1_add #(
        .N            (N),
        .PARALLEL_DEC (PARALLEL_DEC)
    ) u_add (
        .op_a    (term_1),
        .op_b    (term_2),
        .op_c    (term_3),
        .sum     (z_sum),
        .sum_dec (z_dec)
    );

    always_comb begin
        dig_hi  = borrow ? z_dec : z_sum;
        dig_mid = sub_w[N-1:0];
    end

endmodule

// File: rtl/rnscmp_mag.sv
// Unsigned magnitude compare of one digit pair.
module rnscmp_mag
    import rnscmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] dig_x,
    input  logic [W-1:0] dig_y,
    output digit_cmp_t   res
);
    always_comb begin
        res.e = (dig_x == dig_y);
        res.c = (dig_x >  dig_y);
    end
endmodule

// File: rtl/rnscmp_lex.sv
// Lexicographic compare of two three-digit kernels, high digit first.
module rnscmp_lex
    import rnscmp_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] hi_x,
    input  logic [N-1:0] hi_y,
    input  logic [N-1:0] mid_x,
    input  logic [N-1:0] mid_y,
    input  logic [N:0]   lo_x,
    input  logic [N:0]   lo_y,
    output logic         eq,
    output logic         gt
);
    digit_cmp_t c_hi;
    digit_cmp_t c_mid;
    digit_cmp_t c_lo;
    logic       gt_low2;

    rnscmp_mag #(.W(N))   u_hi  (.dig_x(hi_x),  .dig_y(hi_y),  .res(c_hi));
    rnscmp_mag #(.W(N))   u_mid (.dig_x(mid_x), .dig_y(mid_y), .res(c_mid));
    rnscmp_mag #(.W(N+1)) u_lo  (.dig_x(lo_x),  .dig_y(lo_y),  .res(c_lo));

    always_comb begin
        eq      = c_hi.e & c_mid.e & c_lo.e;
        gt_low2 = c_mid.e ? c_lo.c : c_mid.c;    // first mux
        gt      = c_hi.e  ? gt_low2 : c_hi.c;    // second mux
    end
endmodule

// File: rtl/rnscmp_top.sv
module rnscmp_top
    import rnscmp_pkg::*;
#(
    parameter int N            = 4,
    parameter bit REG_OUT      = 1'b1,
    parameter bit PARALLEL_DEC = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] a_mlo,
    input  logic [N-1:0] a_mmid,
    input  logic [N:0]   a_mhi,
    input  logic [N-1:0] b_mlo,
    input  logic [N-1:0] b_mmid,
    input  logic [N:0]   b_mhi,
    output logic         out_valid,
    output logic         a_eq_b,
    output logic         a_gt_b
);
    localparam int OPS = 2;

    logic [OPS-1:0][N-1:0] mlo_v;
    logic [OPS-1:0][N-1:0] mmid_v;
    logic [OPS-1:0][N:0]   mhi_v;
    logic [OPS-1:0][N-1:0] hi_v;
    logic [OPS-1:0][N-1:0] mid_v;
    logic                  eq_c;
    logic                  gt_c;
    rnscmp_res_t           res_d;
    rnscmp_res_t           res_q;

    always_comb begin
        mlo_v[0]  = a_mlo;
        mlo_v[1]  = b_mlo;
        mmid_v[0] = a_mmid;
        mmid_v[1] = b_mmid;
        mhi_v[0]  = a_mhi;
        mhi_v[1]  = b_mhi;
    end

    for (genvar g = 0; g < OPS; g++) begin : g_op
        rnscmp_kernel #(
            .N            (N),
            .PARALLEL_DEC (PARALLEL_DEC)
        ) u_kern (
            .res_m1  (mlo_v[g]),
            .res_p2  (mmid_v[g]),
            .res_p1  (mhi_v[g]),
            .dig_hi  (hi_v[g]),
            .dig_mid (mid_v[g])
        );
    end

    rnscmp_lex #(.N(N)) u_lex (
        .hi_x  (hi_v[0]),
        .hi_y  (hi_v[1]),
        .mid_x (mid_v[0]),
        .mid_y (mid_v[1]),
        .lo_x  (a_mhi),
        .lo_y  (b_mhi),
        .eq    (eq_c),
        .gt    (gt_c)
    );

    always_comb begin
        res_d.vld = in_valid;
        res_d.eq  = in_valid & eq_c;
        res_d.gt  = in_valid & gt_c;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_d;
            end
        end else begin : g_comb
            always_comb res_q = res_d;
        end
    endgenerate

    assign out_valid = res_q.vld;
    assign a_eq_b    = res_q.eq;
    assign a_gt_b    = res_q.gt;

endmodule

// File: rtl/rnscmp_chk.sv
module rnscmp_chk #(
    parameter int N       = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [N-1:0] a_mlo,
    input logic [N-1:0] a_mmid,
    input logic [N:0]   a_mhi,
    input logic [N-1:0] b_mlo,
    input logic [N-1:0] b_mmid,
    input logic [N:0]   b_mhi,
    input logic         out_valid,
    input logic         a_eq_b,
    input logic         a_gt_b
);
    logic same_in;
    assign same_in = (a_mlo == b_mlo) && (a_mmid == b_mmid) && (a_mhi == b_mhi);

    assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_eq_b && a_gt_b));

    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!a_eq_b && !a_gt_b));

    generate
        if (REG_OUT) begin : g_seq
            assert_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            assert_same_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && same_in) |=> a_eq_b);
            assert_diff_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (a_mhi != b_mhi)) |=> !a_eq_b);
            assert_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && same_in) |=> !a_gt_b);
        end else begin : g_comb
            assert_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == in_valid);
            assert_same_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && same_in) |-> a_eq_b);
            assert_diff_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (a_mhi != b_mhi)) |-> !a_eq_b);
            assert_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && same_in) |-> !a_gt_b);
        end
    endgenerate
endmodule

bind rnscmp_top rnscmp_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_mlo     (a_mlo),
    .a_mmid    (a_mmid),
    .a_mhi     (a_mhi),
    .b_mlo     (b_mlo),
    .b_mmid    (b_mmid),
    .b_mhi     (b_mhi),
    .out_valid (out_valid),
    .a_eq_b    (a_eq_b),
    .a_gt_b    (a_gt_b)
);

// File: tb/rnscmp_top_test.sv
module rnscmp_top_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // N=2 registered, parallel decrement
    logic       a_vld = 1'b0;
    logic [1:0] a_x3 = '0, a_x2 = '0, a_y3 = '0, a_y2 = '0;
    logic [2:0] a_x1 = '0, a_y1 = '0;
    logic       a_ov, a_eq, a_gt;
    // N=3 combinational, cascaded decrement
    logic       b_vld = 1'b0;
    logic [2:0] b_x3 = '0, b_x2 = '0, b_y3 = '0, b_y2 = '0;
    logic [3:0] b_x1 = '0, b_y1 = '0;
    logic       b_ov, b_eq, b_gt;
    // N=5 registered, cascaded decrement
    logic       c_vld = 1'b0;
    logic [4:0] c_x3 = '0, c_x2 = '0, c_y3 = '0, c_y2 = '0;
    logic [5:0] c_x1 = '0, c_y1 = '0;
    logic       c_ov, c_eq, c_gt;

    rnscmp_top #(.N(2), .REG_OUT(1'b1), .PARALLEL_DEC(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(a_vld),
        .a_mlo(a_x3), .a_mmid(a_x2), .a_mhi(a_x1),
        .b_mlo(a_y3), .b_mmid(a_y2), .b_mhi(a_y1),
        .out_valid(a_ov), .a_eq_b(a_eq), .a_gt_b(a_gt));

    rnscmp_top #(.N(3), .REG_OUT(1'b0), .PARALLEL_DEC(1'b0)) uut_n3 (
        .clk(clk), .rst_n(rst_n), .in_valid(b_vld),
        .a_mlo(b_x3), .a_mmid(b_x2), .a_mhi(b_x1),
        .b_mlo(b_y3), .b_mmid(b_y2), .b_mhi(b_y1),
        .out_valid(b_ov), .a_eq_b(b_eq), .a_gt_b(b_gt));

    rnscmp_top #(.N(5), .REG_OUT(1'b1), .PARALLEL_DEC(1'b0)) uut_n5 (
        .clk(clk), .rst_n(rst_n), .in_valid(c_vld),
        .a_mlo(c_x3), .a_mmid(c_x2), .a_mhi(c_x1),
        .b_mlo(c_y3), .b_mmid(c_y2), .b_mhi(c_y1),
        .out_valid(c_ov), .a_eq_b(c_eq), .a_gt_b(c_gt));

    function automatic string tag_of(int n, int xv, int yv);
        int p  = 1 << n;
        int x1 = xv % (p + 1);
        int y1 = yv % (p + 1);
        if (x1 == p || y1 == p) return "R4";
        if ((xv % p) < x1 || (yv % p) < y1) return "R5";
        return "R1";
    endfunction

    task automatic check_bit(string req, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%0b exp=%0b", req, what, got, exp);
        end
    endtask

    task automatic score(string tag, int xv, int yv, logic ov, logic geq, logic ggt);
        string info;
        info = $sformatf("[%s] x=%0d y=%0d", tag, xv, yv);
        check_bit("R1", {"eq ", info}, geq, (xv == yv));
        check_bit("R2", {"gt ", info}, ggt, (xv > yv));
        check_bit("R3", {"excl ", info}, geq & ggt, 1'b0);
        check_bit("R6", {"valid ", info}, ov, 1'b1);
    endtask

    task automatic set_a(int xv, int yv);
        a_x3 = 2'(xv % 3); a_x2 = 2'(xv % 4); a_x1 = 3'(xv % 5);
        a_y3 = 2'(yv % 3); a_y2 = 2'(yv % 4); a_y1 = 3'(yv % 5);
    endtask
    task automatic set_b(int xv, int yv);
        b_x3 = 3'(xv % 7); b_x2 = 3'(xv % 8); b_x1 = 4'(xv % 9);
        b_y3 = 3'(yv % 7); b_y2 = 3'(yv % 8); b_y1 = 4'(yv % 9);
    endtask
    task automatic set_c(int xv, int yv);
        c_x3 = 5'(xv % 31); c_x2 = 5'(xv % 32); c_x1 = 6'(xv % 33);
        c_y3 = 5'(yv % 31); c_y2 = 5'(yv % 32); c_y1 = 6'(yv % 33);
    endtask

    initial begin
        #(CLK_PERIOD * 120000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R8: equal operands held valid during reset must not show through
        a_vld = 1'b1; set_a(7, 7);
        c_vld = 1'b1; set_c(9, 9);
        repeat (3) @(posedge clk);
        #1;
        check_bit("R8", "uut out_valid in reset", a_ov, 1'b0);
        check_bit("R8", "uut eq in reset", a_eq, 1'b0);
        check_bit("R8", "uut_n5 out_valid in reset", c_ov, 1'b0);
        check_bit("R8", "uut_n5 eq in reset", c_eq, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        c_vld = 1'b0;

        // R6: result holds until the next edge, then follows the new pair
        @(negedge clk); set_a(5, 5);
        @(posedge clk); #1;
        check_bit("R6", "eq after edge", a_eq, 1'b1);
        @(negedge clk); set_a(37, 12);
        #1;
        check_bit("R6", "eq held before edge", a_eq, 1'b1);
        check_bit("R6", "gt held before edge", a_gt, 1'b0);
        @(posedge clk); #1;
        check_bit("R6", "gt after edge", a_gt, 1'b1);
        check_bit("R6", "eq after edge", a_eq, 1'b0);

        // Full sweep N=2 (R1 R2 R3 R4 R5)
        for (int xv = 0; xv < 60; xv++) begin
            for (int yv = 0; yv < 60; yv++) begin
                @(negedge clk); set_a(xv, yv);
                @(posedge clk); #1;
                score(tag_of(2, xv, yv), xv, yv, a_ov, a_eq, a_gt);
            end
        end

        // R7: no valid, outputs quiet even for equal or larger operands
        @(negedge clk); a_vld = 1'b0; set_a(11, 11);
        @(posedge clk); #1;
        check_bit("R7", "out_valid idle", a_ov, 1'b0);
        check_bit("R7", "eq idle", a_eq, 1'b0);
        @(negedge clk); set_a(50, 3);
        @(posedge clk); #1;
        check_bit("R7", "gt idle", a_gt, 1'b0);

        // N=3 combinational, cascaded decrement (R9)
        b_vld = 1'b1;
        for (int xv = 0; xv < 504; xv++) begin
            for (int yv = 0; yv < 505; yv += 7) begin
                int yy = (yv >= 504) ? xv : yv;
                @(negedge clk); set_b(xv, yy); #1;
                score({"R9 ", tag_of(3, xv, yy)}, xv, yy, b_ov, b_eq, b_gt);
            end
        end
        @(negedge clk); b_vld = 1'b0; set_b(100, 100); #1;
        check_bit("R7", "n3 eq idle", b_eq, 1'b0);
        check_bit("R6", "n3 out_valid same cycle", b_ov, 1'b0);

        // N=5 random plus equal pairs
        c_vld = 1'b1;
        for (int k = 0; k < 5000; k++) begin
            int xv = int'($urandom % 32736);
            int yv = (k % 25 == 0) ? xv : int'($urandom % 32736);
            @(negedge clk); set_c(xv, yv);
            @(posedge clk); #1;
            score({"R9 ", tag_of(5, xv, yv)}, xv, yv, c_ov, c_eq, c_gt);
        end
        foreach (uut_bound_pairs[i]) begin
            @(negedge clk); set_c(uut_bound_pairs[i][0], uut_bound_pairs[i][1]);
            @(posedge clk); #1;
            score({"R4 ", tag_of(5, uut_bound_pairs[i][0], uut_bound_pairs[i][1])},
                  uut_bound_pairs[i][0], uut_bound_pairs[i][1], c_ov, c_eq, c_gt);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Boundary pairs for N=5: top residue 32 (x mod 33 == 32), range ends
    int uut_bound_pairs [6][2] = '{
        '{32, 65}, '{32735, 0}, '{0, 32735}, '{32, 32}, '{32735, 32734}, '{65, 32}
    };

endmodule